// File: doc/BRIEF.md
# Shared-Engine 8x8 Forward DCT

This block takes 8x8 tiles of unsigned 8-bit pixels, one per cycle in raster order, and returns the 64 coefficients of their two-dimensional forward DCT as signed 12-bit values. Each pixel is first moved into a signed range by subtracting 128. The block has a single one-dimensional 8-point DCT datapath. That datapath produces one dot product per cycle and serves both passes.

The first pass transforms each completed row and writes the eight results into a transposing register store. Each result goes to the slot of its frequency index, so that reading one frequency group back gives a column of the intermediate tile. The second pass starts only after all 64 intermediate values are stored. It runs the same datapath over those columns and emits the coefficients in row-major order.

Input and output both use valid/ready handshakes. A start-of-tile flag on the input puts the sample counter back to position 0. The input stays closed from the 64th accepted pixel until the last coefficient has left, so only one tile is inside the block at a time.

Top module: `dct2d_shared`

## Requirements
- R1: A tile whose 64 pixels all equal p gives coefficient 0 equal to exactly 8*(p-128), and all 63 other coefficients equal exactly 0.
- R2: Every coefficient F(v,u) is within ±1 of the rounded value of 0.25*c(u)*c(v)*sum over y,x of (pixel(y,x)-128)*cos((2x+1)uπ/16)*cos((2y+1)vπ/16). Here c(0)=1/√2 and c(k)=1 otherwise, y is the row, x is the column, v is the vertical frequency and u is the horizontal frequency.
- R3: Each tile produces exactly 64 output transfers, in the order index = 8*v + u. out_last is high on the 64th transfer only, and no further out_valid follows it.
- R4: in_ready is low from the acceptance of the 64th pixel until the last coefficient is accepted. It is high again in the cycle after that acceptance, and it is never high while out_valid is high.
- R5: While out_valid is high and out_ready is low, out_valid, out_coef and out_last hold their values into the next cycle.
- R6: A pixel presented with in_first high is taken as position 0 (row 0, column 0) of a new tile. Any pixels accepted before it that do not complete a tile are discarded and do not affect the coefficients.
- R7: No coefficient is presented before all 64 pixels of the tile have been accepted. The second pass never runs in a cycle where a first-pass result is being written or a row transform is unfinished.
- R8: In the cycle after reset is released, out_valid is low and in_ready is high.
- R9: A tile offered at full rate is accepted in 64 consecutive cycles. A new row is handed to the shared datapath only when the previous row's eighth product is being formed or the datapath is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_first | input | 1 | Offered pixel is position 0 of a tile |
| in_pixel | input | 8 | Unsigned pixel value |
| out_valid | output | 1 | Coefficient offered |
| out_ready | input | 1 | Consumer accepts the coefficient |
| out_coef | output | 12 | Signed coefficient, row-major order |
| out_last | output | 1 | Marks coefficient 63 of the tile |

## Verification
The assertions check the handshake rules on every cycle. These are: the input is closed whenever a coefficient is offered, output values are held under back-pressure, and the post-reset state is correct. They also check the sharing rules of the datapath: a row is only handed over when the datapath is free, and column work never coincides with a first-pass write or an unfinished row. Only the bench's tiles can show the numbers themselves. It compares every coefficient against a real-valued transform and checks exact zeros for flat tiles. It sweeps a single impulse over every pixel position, checks coefficient order and the last flag, and tests resynchronisation with a start flag after 1, 13 and 63 stray pixels. It also runs tiles with random input gaps and output stalls.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;

    // Tile geometry (the weight generator below is written for 8 points)
    localparam int N        = 8;
    localparam int LOG_N    = 3;
    localparam int BLK      = N * N;
    localparam int ADDR_W   = 2 * LOG_N;

    // Data widths
    localparam int PIX_W    = 8;
    localparam int COS_FRAC = 12;
    localparam int W_W      = COS_FRAC + 1;
    localparam int MID_FRAC = 6;
    localparam int MID_W    = PIX_W + 3 + MID_FRAC;
    localparam int ACC_W    = MID_W + W_W + LOG_N;
    localparam int COEF_W   = 12;

    typedef logic signed [MID_W-1:0]  mid_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [W_W-1:0]    wgt_t;
    typedef logic [LOG_N-1:0]         idx_t;
    typedef logic [ADDR_W-1:0]        addr_t;
    typedef mid_t [N-1:0]             mid_vec_t;

    typedef enum logic [1:0] {
        PH_LOAD,
        PH_DRAIN,
        PH_COL
    } phase_t;

    // Work item handed to the shared datapath
    typedef struct packed {
        logic  valid;
        logic  col_pass;
        idx_t  freq;
        addr_t tag;
        logic  last;
    } eng_req_t;

    // Registered datapath result
    typedef struct packed {
        logic  valid;
        logic  col_pass;
        addr_t tag;
        logic  last;
        mid_t  mid;
        coef_t coef;
    } eng_res_t;

    // 0.5*cos(k*pi/16) scaled by 2^COS_FRAC, k = 0..8
    function automatic wgt_t half_cos(input int k);
        case (k)
            0:       return wgt_t'(2048);
            1:       return wgt_t'(2009);
            2:       return wgt_t'(1892);
            3:       return wgt_t'(1703);
            4:       return wgt_t'(1448);
            5:       return wgt_t'(1138);
            6:       return wgt_t'(784);
            7:       return wgt_t'(400);
            default: return wgt_t'(0);
        endcase
    endfunction

    // Orthonormal DCT basis weight for frequency u at position x
    function automatic wgt_t dct_weight(input idx_t u, input idx_t x);
        int   ph;
        logic neg;
        wgt_t w;
        ph  = ((2 * int'(x) + 1) * int'(u)) % 32;
        neg = 1'b0;
        if (ph > 16) ph = 32 - ph;
        if (ph > 8) begin
            ph  = 16 - ph;
            neg = 1'b1;
        end
        if (u == '0) w = wgt_t'(1448);   // (1/(2*sqrt 2)) * 2^12
        else         w = half_cos(ph);
        return neg ? -w : w;
    endfunction

    // Round half up, then arithmetic shift right
    function automatic acc_t round_shift(input acc_t v, input int sh);
        return (v + (acc_t'(1) <<< (sh - 1))) >>> sh;
    endfunction

    // Clip to the signed range of a w-bit number
    function automatic acc_t clip(input acc_t v, input int w);
        acc_t hi;
        acc_t lo;
        hi = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
        lo = -hi - acc_t'(1);
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/dct_row_gather.sv
module dct_row_gather
    import dct2d_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             first,
    input  logic [PIX_W-1:0] pixel,
    output logic             hand,
    output idx_t             hand_row,
    output mid_vec_t         hand_vec
);

    localparam logic [PIX_W:0] LVL = (PIX_W+1)'(1 << (PIX_W - 1));

    idx_t     col_q;
    idx_t     row_q;
    idx_t     col_pos;
    idx_t     row_pos;
    mid_vec_t buf_q;
    logic signed [PIX_W:0] lvl;
    mid_t     smp;

    always_comb begin
        col_pos  = first ? '0 : col_q;
        row_pos  = first ? '0 : row_q;
        lvl      = $signed({1'b0, pixel}) - $signed(LVL);
        smp      = mid_t'(lvl) <<< MID_FRAC;
        hand     = take && (col_pos == idx_t'(N - 1));
        hand_row = row_pos;
        hand_vec = buf_q;
        hand_vec[col_pos] = smp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (take) begin
            buf_q[col_pos] <= smp;
            col_q          <= col_pos + idx_t'(1);
            row_q          <= (col_pos == idx_t'(N - 1)) ? row_pos + idx_t'(1) : row_pos;
        end
    end

endmodule

// File: rtl/dct_engine.sv
module dct_engine
    import dct2d_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  eng_req_t req_i,
    input  mid_vec_t opnd_i,
    output eng_res_t res_o
);

    acc_t prod [N];
    acc_t acc;

    for (genvar i = 0; i < N; i++) begin : g_tap
        wgt_t wt;
        assign wt      = dct_weight(req_i.freq, idx_t'(i));
        assign prod[i] = acc_t'(opnd_i[i]) * acc_t'(wt);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) acc = acc + prod[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
        end else if (adv) begin
            res_o.valid    <= req_i.valid;
            res_o.col_pass <= req_i.col_pass;
            res_o.tag      <= req_i.tag;
            res_o.last     <= req_i.last;
            res_o.mid      <= mid_t'(clip(round_shift(acc, COS_FRAC), MID_W));
            res_o.coef     <= coef_t'(clip(round_shift(acc, COS_FRAC + MID_FRAC), COEF_W));
        end
    end

endmodule

// File: rtl/dct_tpose_mem.sv
module dct_tpose_mem
    import dct2d_pkg::*;
(
    input  logic     clk,
    input  logic     we,
    input  addr_t    waddr,
    input  mid_t     wdata,
    input  idx_t     rsel,
    output mid_vec_t rvec
);

    mid_t cells [BLK];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // slot = frequency*N + row, so one frequency group is one column
    always_comb begin
        for (int j = 0; j < N; j++) rvec[j] = cells[{rsel, idx_t'(j)}];
    end

endmodule

// File: rtl/dct2d_shared.sv
module dct2d_shared
    import dct2d_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_first,
    input  logic [PIX_W-1:0]         in_pixel,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [COEF_W-1:0] out_coef,
    output logic                     out_last
);

    phase_t   phase;
    logic     take;
    logic     hand;
    idx_t     hand_row;
    mid_vec_t hand_vec;

    logic     rp_busy;
    idx_t     rp_k;
    idx_t     rp_row;
    mid_vec_t rp_vec;

    addr_t    cp_cnt;
    logic     cp_pend;

    eng_req_t req;
    mid_vec_t opnd;
    mid_vec_t col_vec;
    eng_res_t res;
    logic     adv;
    logic     mem_we;

    assign in_ready  = (phase == PH_LOAD);
    assign take      = in_valid && in_ready;
    assign out_valid = res.valid && res.col_pass;
    assign out_coef  = res.coef;
    assign out_last  = res.last;
    assign adv       = !(out_valid && !out_ready);
    assign mem_we    = res.valid && !res.col_pass;

    dct_row_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .first    (in_first),
        .pixel    (in_pixel),
        .hand     (hand),
        .hand_row (hand_row),
        .hand_vec (hand_vec)
    );

    dct_tpose_mem u_tmem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (res.tag),
        .wdata (res.mid),
        .rsel  (cp_cnt[LOG_N-1:0]),
        .rvec  (col_vec)
    );

    // Work selection for the shared datapath
    always_comb begin
        if (phase == PH_COL) begin
            req.valid    = cp_pend;
            req.col_pass = 1'b1;
            req.freq     = cp_cnt[ADDR_W-1 -: LOG_N];
            req.tag      = cp_cnt;
            req.last     = (cp_cnt == addr_t'(BLK - 1));
            opnd         = col_vec;
        end else begin
            req.valid    = rp_busy;
            req.col_pass = 1'b0;
            req.freq     = rp_k;
            req.tag      = {rp_k, rp_row};
            req.last     = 1'b0;
            opnd         = rp_vec;
        end
    end

    dct_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .req_i  (req),
        .opnd_i (opnd),
        .res_o  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_LOAD;
            rp_busy <= 1'b0;
            rp_k    <= '0;
            rp_row  <= '0;
            cp_cnt  <= '0;
            cp_pend <= 1'b0;
        end else begin
            if (hand) begin
                rp_vec  <= hand_vec;
                rp_row  <= hand_row;
                rp_k    <= '0;
                rp_busy <= 1'b1;
            end else if (rp_busy) begin
                rp_k <= rp_k + idx_t'(1);
                if (rp_k == idx_t'(N - 1)) rp_busy <= 1'b0;
            end

            case (phase)
                PH_LOAD: begin
                    if (hand && hand_row == idx_t'(N - 1)) phase <= PH_DRAIN;
                end
                PH_DRAIN: begin
                    if (mem_we && res.tag == addr_t'(BLK - 1)) begin
                        phase   <= PH_COL;
                        cp_cnt  <= '0;
                        cp_pend <= 1'b1;
                    end
                end
                PH_COL: begin
                    if (adv && cp_pend) begin
                        cp_cnt <= cp_cnt + addr_t'(1);
                        if (cp_cnt == addr_t'(BLK - 1)) cp_pend <= 1'b0;
                    end
                    if (out_valid && out_ready && out_last) phase <= PH_LOAD;
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    assert_ready_closed_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_last)));

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    assert_col_isolated_R7: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.col_pass) |-> (!mem_we && !rp_busy));

    assert_handoff_free_R9: assert property (@(posedge clk) disable iff (rst)
        hand |-> (!rp_busy || rp_k == idx_t'(N - 1)));

endmodule

// File: tb/dct2d_shared_bench.sv
module dct2d_shared_bench;
    import dct2d_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic        in_first;
    logic [7:0]  in_pixel;
    logic        out_valid;
    logic        out_ready;
    logic signed [COEF_W-1:0] out_coef;
    logic        out_last;

    int n_chk  = 0;
    int n_fail = 0;

    int  pix   [64];
    real expv  [64];
    int  got   [64];
    int  gotl  [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dct2d_shared u_dct2d_shared (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_first  (in_first),
        .in_pixel  (in_pixel),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_coef  (out_coef),
        .out_last  (out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic compute_expected();
        real pi_v = 3.14159265358979;
        for (int v = 0; v < 8; v++) begin
            for (int u = 0; u < 8; u++) begin
                real s  = 0.0;
                real cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                real cv = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                for (int y = 0; y < 8; y++) begin
                    for (int x = 0; x < 8; x++) begin
                        s += (pix[y*8+x] - 128) *
                             $cos((2*x+1) * u * pi_v / 16.0) *
                             $cos((2*y+1) * v * pi_v / 16.0);
                    end
                end
                expv[v*8+u] = 0.25 * cu * cv * s;
            end
        end
    endtask

    // junk: stray pixels sent before the flagged tile; gap/bp: percent idle
    task automatic run_block(input int junk, input int gap, input int bp,
                             input bit rate_chk, input bit flat_chk);
        int total  = junk + 64;
        int sidx   = 0;
        int oc     = 0;
        int cyc    = 0;
        int t_first = 0;
        int t_last  = 0;
        int early  = 0;
        compute_expected();
        while (oc < 64) begin
            @(negedge clk);
            cyc++;
            out_ready = ($urandom_range(99) >= bp);
            if (out_valid) begin
                chk(!in_ready, "R4", int'(in_ready), 0);
                if (sidx < total) early++;
                if (out_ready) begin
                    got[oc]  = out_coef;
                    gotl[oc] = int'(out_last);
                    oc++;
                end
            end
            if (sidx < total && $urandom_range(99) >= gap) begin
                in_valid = 1'b1;
                in_first = (sidx == junk);
                in_pixel = (sidx < junk) ? 8'($urandom_range(255)) : 8'(pix[sidx-junk]);
                if (in_ready) begin
                    if (sidx == junk)      t_first = cyc;
                    if (sidx == total - 1) t_last  = cyc;
                    sidx++;
                end
            end else begin
                in_valid = 1'b0;
                in_first = 1'b0;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready == 1'b1, "R4", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R3", int'(out_valid), 0);
        chk(early == 0, "R7", early, 0);
        if (rate_chk) chk(t_last - t_first == 63, "R9", t_last - t_first, 63);
        for (int i = 0; i < 64; i++) begin
            int r = int'(expv[i]);
            int d = got[i] - r;
            chk(gotl[i] == ((i == 63) ? 1 : 0), "R3", gotl[i], (i == 63) ? 1 : 0);
            chk(d <= 1 && d >= -1, (junk > 0) ? "R6" : "R2", got[i], r);
            if (flat_chk) begin
                int e = (i == 0) ? 8 * (pix[0] - 128) : 0;
                chk(got[i] == e, "R1", got[i], e);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual %0d cycles expected completion", WATCHDOG);
        report();
        $finish;
    end

    initial begin
        int flat_vals [5] = '{128, 0, 255, 77, 200};
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_first  = 1'b0;
        in_pixel  = '0;
        out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R8", int'(in_ready), 1);

        // R1: flat tiles
        foreach (flat_vals[k]) begin
            for (int i = 0; i < 64; i++) pix[i] = flat_vals[k];
            run_block(0, 0, 0, 1'b1, 1'b1);
        end

        // R2: single impulse at every position
        for (int p = 0; p < 64; p++) begin
            for (int i = 0; i < 64; i++) pix[i] = 128;
            pix[p] = (p % 2 == 1) ? 0 : 255;
            run_block(0, 0, (p % 4 == 3) ? 50 : 0, 1'b1, 1'b0);
        end

        // R2/R5: structured patterns under output stalls
        for (int i = 0; i < 64; i++) pix[i] = (i % 8) * 36;
        run_block(0, 0, 30, 1'b1, 1'b0);
        for (int i = 0; i < 64; i++) pix[i] = (i / 8) * 36;
        run_block(0, 0, 30, 1'b1, 1'b0);
        for (int i = 0; i < 64; i++) pix[i] = (((i % 8) + (i / 8)) % 2 == 1) ? 255 : 0;
        run_block(0, 0, 60, 1'b1, 1'b0);

        // R2/R5: random tiles with input gaps and output stalls
        for (int b = 0; b < 16; b++) begin
            for (int i = 0; i < 64; i++) pix[i] = $urandom_range(255);
            run_block(0, 25, 40, 1'b0, 1'b0);
        end

        // R6: stray pixels before a flagged tile
        for (int i = 0; i < 64; i++) pix[i] = $urandom_range(255);
        run_block(13, 0, 0, 1'b1, 1'b0);
        for (int i = 0; i < 64; i++) pix[i] = $urandom_range(255);
        run_block(63, 10, 20, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) pix[i] = $urandom_range(255);
        run_block(1, 0, 0, 1'b1, 1'b0);

        // R9: back-to-back full-rate tiles
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 64; i++) pix[i] = $urandom_range(255);
            run_block(0, 0, 0, 1'b1, 1'b0);
        end

        report();
        $finish;
    end

endmodule